// File: doc/BRIEF.md
# Serial Audio DAC Transmitter

The block feeds a serial audio DAC from a parallel sample FIFO. It runs entirely in the master clock domain (18.432 MHz in the target system) and divides that clock into a bit clock and a frame (left/right) clock. With the default parameters a bit slot lasts 24 master cycles, giving 768 kHz, and a frame holds 16 bit slots, giving 384 master cycles, or 48 kHz. Once per frame the block pulls one 16-bit word from the FIFO and shifts it out MSB-first on a single data line. The word spans the whole frame, across both levels of the frame clock.

The FIFO side follows a pull discipline. The FIFO reports emptiness, the block answers with a one-cycle read strobe, and the FIFO must present the word during the next master cycle. The block applies no back-pressure in the other direction. A word that has been read is always consumed. When no word is available at the read point, the frame is filled with zeros and an underrun pulse is raised. Words that arrive after that point stay in the FIFO for the next frame.

Top module: `dac_serial_tx`

## Requirements
- R1: While `rst` is high, and in the first master cycle after it falls, `bclk`, `lrclk`, `sdata`, `fifo_rd` and `underrun` are all low. The block comes out of reset at the midpoint of an idle frame, so the first frame boundary follows FRAME/2 master cycles after reset release.
- R2: `bclk` has a period of 2×BIT_HALF master cycles. It is low for the first BIT_HALF cycles of each bit slot and high for the remaining BIT_HALF cycles.
- R3: `lrclk` has a period of WORD_W bit slots (2×BIT_HALF×WORD_W master cycles, 384 by default). It is high during bit slots 0 to WORD_W/2−1 of a frame and low during the rest.
- R4: `fifo_rd` is a single-cycle pulse issued only in the second-to-last master cycle of a frame, and only if `fifo_empty` is low in that cycle. `fifo_empty` is ignored in every other cycle.
- R5: The word on `fifo_rdata` during the master cycle after `fifo_rd` is the word sent in the next frame. `fifo_rdata` is ignored in all other cycles.
- R6: During bit slot k of a frame (k = 0 first), `sdata` carries bit WORD_W−1−k of the frame's word, so transmission is MSB-first. `sdata` changes only on the cycle in which `bclk` falls.
- R7: If `fifo_empty` is high in the read cycle, no read is issued and `underrun` is high for exactly the last master cycle of that frame. The next frame then sends all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | High when the source FIFO holds no word |
| fifo_rdata | input | WORD_W | FIFO word, valid the cycle after `fifo_rd` |
| fifo_rd | output | 1 | One-cycle read strobe to the FIFO |
| bclk | output | 1 | Bit clock to the DAC |
| lrclk | output | 1 | Frame (left/right) clock to the DAC |
| sdata | output | 1 | Serial sample data, MSB-first, changes on falling `bclk` |
| underrun | output | 1 | One-cycle pulse when a frame had no word |

## Verification
The bench builds the block with its default values, BIT_HALF = 12 and WORD_W = 16. This gives the real 24-cycle bit slot and the 384-cycle frame, so every divider compare, including the read cycle two cycles before the frame wrap, is checked at its actual position. About a dozen frames are enough to exercise several contrasting words (all ones, single set MSB or LSB, alternating bits). They also cover a burst of underruns, a word pushed in the exact read cycle, and a word pushed one cycle too late, which must survive into the following frame. A `fifo_rdata` value that is valid only in its capture cycle exposes any off-by-one in the capture timing.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  // strobes produced by the bit-clock divider, one master cycle wide
  typedef struct packed {
    logic slot_pre_end;  // next-to-last master cycle of a bit slot
    logic slot_end;      // last master cycle of a bit slot
  } bit_tick_t;

  // strobes produced by the frame sequencer, one master cycle wide
  typedef struct packed {
    logic req_cycle;     // cycle in which the FIFO may be read
    logic load_cycle;    // cycle whose closing edge loads the shifter
  } frame_tick_t;

  function automatic int safe_clog2(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dac_tx_bitdiv.sv
module dac_tx_bitdiv
  import dac_tx_pkg::*;
#(
  parameter int BIT_HALF = 12
) (
  input  logic      clk,
  input  logic      rst,
  output logic      bclk,
  output bit_tick_t tick
);

  localparam int BIT_PERIOD = 2 * BIT_HALF;
  localparam int PH_W       = safe_clog2(BIT_PERIOD);

  logic [PH_W-1:0] ph_q;
  logic            bclk_q;
  logic            at_last;
  logic            at_mid;
  logic            at_pre;

  assign at_last = (ph_q == PH_W'(BIT_PERIOD - 1));
  assign at_mid  = (ph_q == PH_W'(BIT_HALF - 1));
  assign at_pre  = (ph_q == PH_W'(BIT_PERIOD - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
    end else if (at_last) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // bclk is its own register so the pin never decodes the counter
  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
    end else if (at_mid) begin
      bclk_q <= 1'b1;
    end else if (at_last) begin
      bclk_q <= 1'b0;
    end
  end

  assign bclk              = bclk_q;
  assign tick.slot_end     = at_last;
  assign tick.slot_pre_end = at_pre;

  // R2
  bclk_low_half_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q < PH_W'(BIT_HALF)) |-> !bclk_q);

  // R2
  bclk_high_half_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q >= PH_W'(BIT_HALF)) |-> bclk_q);

endmodule

// File: rtl/dac_tx_framer.sv
module dac_tx_framer
  import dac_tx_pkg::*;
#(
  parameter int SLOTS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  bit_tick_t   btick,
  output logic        lrclk,
  output frame_tick_t ftick
);

  localparam int SL_W       = safe_clog2(SLOTS);
  localparam int HALF_SLOTS = SLOTS / 2;

  logic [SL_W-1:0] slot_q;
  logic            lr_q;
  logic            last_slot;

  assign last_slot = (slot_q == SL_W'(SLOTS - 1));

  // reset lands mid-frame so the frame clock starts low
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SL_W'(HALF_SLOTS);
    end else if (btick.slot_end) begin
      if (last_slot) begin
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q <= 1'b0;
    end else if (btick.slot_end) begin
      if (last_slot) begin
        lr_q <= 1'b1;
      end else if (slot_q == SL_W'(HALF_SLOTS - 1)) begin
        lr_q <= 1'b0;
      end
    end
  end

  assign lrclk            = lr_q;
  assign ftick.req_cycle  = last_slot && btick.slot_pre_end;
  assign ftick.load_cycle = last_slot && btick.slot_end;

  // R3
  lr_level_chk: assert property (@(posedge clk) disable iff (rst)
    lr_q == (slot_q < SL_W'(HALF_SLOTS)));

endmodule

// File: rtl/dac_tx_shifter.sv
module dac_tx_shifter
  import dac_tx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  bit_tick_t         btick,
  input  frame_tick_t       ftick,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  output logic              sdata,
  output logic              underrun
);

  logic [WORD_W-1:0] sreg_q;
  logic              took_q;
  logic              und_q;
  logic              rd_now;

  assign rd_now = ftick.req_cycle && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      took_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      took_q <= rd_now;
      und_q  <= ftick.req_cycle && fifo_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
    end else if (ftick.load_cycle) begin
      sreg_q <= took_q ? fifo_rdata : '0;
    end else if (btick.slot_end) begin
      sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
    end
  end

  assign fifo_rd  = rd_now;
  assign sdata    = sreg_q[WORD_W-1];
  assign underrun = und_q;

  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> !fifo_rd);

  // R4
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !fifo_empty);

  // R7
  und_single_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);

  // R7
  und_zero_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> (sreg_q == '0));

endmodule

// File: rtl/dac_serial_tx.sv
module dac_serial_tx
  import dac_tx_pkg::*;
#(
  parameter int BIT_HALF = 12,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  output logic              bclk,
  output logic              lrclk,
  output logic              sdata,
  output logic              underrun
);

  bit_tick_t   btick;
  frame_tick_t ftick;

  dac_tx_bitdiv #(
    .BIT_HALF(BIT_HALF)
  ) u_bitdiv (
    .clk (clk),
    .rst (rst),
    .bclk(bclk),
    .tick(btick)
  );

  dac_tx_framer #(
    .SLOTS(WORD_W)
  ) u_framer (
    .clk  (clk),
    .rst  (rst),
    .btick(btick),
    .lrclk(lrclk),
    .ftick(ftick)
  );

  dac_tx_shifter #(
    .WORD_W(WORD_W)
  ) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .btick     (btick),
    .ftick     (ftick),
    .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata),
    .fifo_rd   (fifo_rd),
    .sdata     (sdata),
    .underrun  (underrun)
  );

  // R6
  sdata_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(bclk));

  // R3
  lr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lrclk) |-> $fell(bclk));

endmodule

// File: tb/dac_serial_tx_bench.sv
module dac_serial_tx_bench;

  localparam int CLK_P    = 10;
  localparam int BIT_HALF = 12;
  localparam int WORD_W   = 16;
  localparam int BITP     = 2 * BIT_HALF;
  localparam int FRAME    = BITP * WORD_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fifo_empty = 1'b1;
  logic [WORD_W-1:0] fifo_rdata = '0;
  logic              fifo_rd, bclk, lrclk, sdata, underrun;

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] fq[$];

  always #(CLK_P / 2) clk = ~clk;

  dac_serial_tx #(
    .BIT_HALF(BIT_HALF),
    .WORD_W  (WORD_W)
  ) u_dac_serial_tx (
    .clk       (clk),
    .rst       (rst),
    .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata),
    .fifo_rd   (fifo_rd),
    .bclk      (bclk),
    .lrclk     (lrclk),
    .sdata     (sdata),
    .underrun  (underrun)
  );

  task automatic check1(input string req, input string what, input logic got,
                        input logic exp, input int fr, input int pos);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s frame %0d pos %0d: got %b expected %b",
               req, what, fr, pos, got, exp);
    end
  endtask

  // schedule of FIFO pushes by frame index and position in frame
  task automatic stim(input int fr, input int pos);
    if (fr == 0 && pos == 200) begin
      fq.push_back(16'hA5C3);
      fq.push_back(16'h8001);
      fq.push_back(16'hFFFF);
    end
    if (fr == 5 && pos == FRAME - 2) fq.push_back(16'h7FFE);  // same cycle as read
    if (fr == 6 && pos == FRAME - 1) fq.push_back(16'h1234);  // one cycle late
    if (fr == 8 && pos == 10) begin
      fq.push_back(16'h0001);
      fq.push_back(16'h8000);
      fq.push_back(16'h5555);
    end
  endtask

  initial begin
    int pos;
    int fr;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] nxt;
    logic taken;
    logic pend_pop;
    // R1: outputs during reset
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check1("R1", "bclk", bclk, 1'b0, -1, i);
      check1("R1", "lrclk", lrclk, 1'b0, -1, i);
      check1("R1", "sdata", sdata, 1'b0, -1, i);
      check1("R1", "fifo_rd", fifo_rd, 1'b0, -1, i);
      check1("R1", "underrun", underrun, 1'b0, -1, i);
    end
    rst = 1'b0;
    pos = FRAME / 2;
    fr = 0;
    cur = '0;
    nxt = '0;
    taken = 1'b1;
    pend_pop = 1'b0;
    while (fr < 13) begin
      fifo_rdata = 16'hDEAD;
      if (pend_pop) fifo_rdata = fq.pop_front();
      stim(fr, pos);
      fifo_empty = (fq.size() == 0);
      #1;
      begin
        logic e_bclk, e_lr, e_sd, e_rd, e_und;
        e_bclk = ((pos % BITP) >= BIT_HALF);
        e_lr   = (pos < FRAME / 2);
        e_sd   = cur[WORD_W - 1 - (pos / BITP)];
        e_rd   = (pos == FRAME - 2) && (fq.size() != 0);
        e_und  = (pos == FRAME - 1) && !taken;
        if (pos == FRAME - 2) begin
          taken = (fq.size() != 0);
          nxt = taken ? fq[0] : '0;
        end
        // first cycle after release also falls under R1
        check1((fr == 0 && pos == FRAME / 2) ? "R1" : "R2", "bclk", bclk, e_bclk, fr, pos);
        check1("R3", "lrclk", lrclk, e_lr, fr, pos);
        check1("R5 R6", "sdata", sdata, e_sd, fr, pos);
        check1("R4", "fifo_rd", fifo_rd, e_rd, fr, pos);
        check1("R7", "underrun", underrun, e_und, fr, pos);
        pend_pop = e_rd;
      end
      @(negedge clk);
      pos++;
      if (pos == FRAME) begin
        pos = 0;
        fr++;
        cur = nxt;
      end
    end
    // R4: the late word must still be gone and the last three consumed
    checks++;
    if (fq.size() != 0) begin
      errors++;
      $display("FAIL R4 fifo left with %0d words, expected 0", fq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule